// File: doc/BRIEF.md
# Indexed Bit and Shift Execution Unit

This unit executes the bit-manipulation instruction group that follows the 0xCB opcode byte. Each operation takes one operand byte, the operation byte and the current flag byte, which also carries the incoming carry. It returns the modified byte, a new flag byte and write strobes that say where the result goes. Address generation, the memory bus and the register file sit outside the unit. It only reports whether memory, a register or both should be written, and which register index to use.

The unit has two modes. In the displacement-indexed mode the operand comes from memory and the result always goes back to memory. The result is also copied into the register named by the low three bits of the operation byte, unless that field is 6. In the plain mode the low field alone picks the target: a register for the values 0–5 and 7, or the memory operand for 6. The shift family includes the extra left-shift slot at 0x30–0x37, which behaves exactly like the arithmetic left shift.

Results are registered. A one-cycle `start_i` strobe leads to a one-cycle `valid_o` pulse on the next clock edge. The data outputs then hold their value until the next strobe.

Top module: `idx_bitshift_unit`

## Requirements
- R1: While reset is asserted and directly after it, `valid_o`, `mem_we_o` and `reg_we_o` are 0, and `result_o`, `flags_o` and `reg_idx_o` are 0.
- R2: A strobe on `start_i` at one rising edge makes `valid_o` 1 for exactly the following clock cycle, and the outputs of that operation appear in that same cycle.
- R3: For op[7:6]=00, op[5:3] picks the shift. For 0 (rotate left circular), bit 7 goes to both carry and bit 0. For 1 (rotate right circular), bit 0 goes to both carry and bit 7. For 2 (rotate left through carry), carry-in enters bit 0 and bit 7 leaves to carry. For 3 (rotate right through carry), carry-in enters bit 7 and bit 0 leaves to carry.
- R4: Shift codes 4 and 6 (ops 0x20–0x27 and 0x30–0x37) give identical results. The byte moves left, a zero enters bit 0 and bit 7 goes to carry.
- R5: Shift code 5 moves right, keeps bit 7 and sends bit 0 to carry. Shift code 7 moves right, puts zero in bit 7 and sends bit 0 to carry.
- R6: After any shift the flag byte is {S=result[7], Z=(result==0), flags_i[5], H=0, flags_i[3], P=even parity of result (1 when the count of ones is even), N=0, C=bit shifted out}, from bit 7 down to bit 0. Carry-in is flags_i[0].
- R7: For op[7:6]=10 (RES), bit op[5:3] of the operand is cleared. For op[7:6]=11 (SET), that bit is set. In both cases `flags_o` equals `flags_i`.
- R8: In the indexed mode with op[2:0] not 6, a shift, RES or SET raises `mem_we_o` and `reg_we_o` together. `reg_idx_o` equals op[2:0], with index order 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 7=A.
- R9: In the indexed mode with op[2:0]=6, only `mem_we_o` is raised.
- R10: In the plain mode, op[2:0]=6 raises only `mem_we_o`. Any other low field raises only `reg_we_o`, with `reg_idx_o` equal to op[2:0].
- R11: Ops 0x40–0x7F raise neither write strobe, return the operand unchanged and pass `flags_i` through, while `valid_o` still pulses.
- R12: Without a strobe the write strobes stay 0, and `result_o` and `flags_o` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle strobe that launches an operation |
| indexed_i | input | 1 | 1 selects the displacement-indexed mode, 0 the plain mode |
| op_i | input | 8 | Operation byte following 0xCB |
| opnd_i | input | W | Operand byte (memory or register value) |
| flags_i | input | 8 | Current flag byte; bit 0 is carry-in |
| valid_o | output | 1 | One-cycle pulse marking a finished operation |
| result_o | output | W | Modified byte |
| flags_o | output | 8 | New flag byte |
| mem_we_o | output | 1 | Write the result back to the memory operand |
| reg_we_o | output | 1 | Write the result to register `reg_idx_o` |
| reg_idx_o | output | 3 | Destination register index |

## Verification
The bench builds the unit with its default width W=8. With that width the 3-bit bit-select field reaches every bit, so all 256 operation codes and every flag position can be exercised. Directed cases cover the carry edges of every rotate and shift, a zero result for the Z and P flags, and RES/SET on bits 1 and 7. Random operations in both modes then exercise all eight low-field targets, including the memory-only field value 6.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

    // Shift selector, taken from op[5:3] when op[7:6] == 2'b00
    typedef enum logic [2:0] {
        SH_RLC = 3'd0,
        SH_RRC = 3'd1,
        SH_RL  = 3'd2,
        SH_RR  = 3'd3,
        SH_SLA = 3'd4,
        SH_SRA = 3'd5,
        SH_SLX = 3'd6,
        SH_SRL = 3'd7
    } shop_e;

    // Operation group, taken from op[7:6]
    typedef enum logic [1:0] {
        GRP_SHIFT = 2'd0,
        GRP_TEST  = 2'd1,
        GRP_CLR   = 2'd2,
        GRP_SETB  = 2'd3
    } grp_e;

    // Flag byte positions
    localparam int FL_S = 7;
    localparam int FL_Z = 6;
    localparam int FL_H = 4;
    localparam int FL_P = 2;
    localparam int FL_N = 1;
    localparam int FL_C = 0;

    // Low-field value that names the memory operand instead of a register
    localparam logic [2:0] MEM_SEL = 3'd6;

endpackage

// File: rtl/bsu_shifter.sv
module bsu_shifter
    import bsu_pkg::*;
#(
    parameter int W = 8
) (
    input  shop_e          sel_i,
    input  logic [W-1:0]   din_i,
    input  logic           cin_i,
    output logic [W-1:0]   dout_o,
    output logic           cout_o
);
    localparam int MSB = W - 1;

    always_comb begin
        dout_o = din_i;
        cout_o = 1'b0;
        unique case (sel_i)
            SH_RLC: begin
                dout_o = {din_i[MSB-1:0], din_i[MSB]};
                cout_o = din_i[MSB];
            end
            SH_RRC: begin
                dout_o = {din_i[0], din_i[MSB:1]};
                cout_o = din_i[0];
            end
            SH_RL: begin
                dout_o = {din_i[MSB-1:0], cin_i};
                cout_o = din_i[MSB];
            end
            SH_RR: begin
                dout_o = {cin_i, din_i[MSB:1]};
                cout_o = din_i[0];
            end
            SH_SLA, SH_SLX: begin
                dout_o = {din_i[MSB-1:0], 1'b0};
                cout_o = din_i[MSB];
            end
            SH_SRA: begin
                dout_o = {din_i[MSB], din_i[MSB:1]};
                cout_o = din_i[0];
            end
            SH_SRL: begin
                dout_o = {1'b0, din_i[MSB:1]};
                cout_o = din_i[0];
            end
            default: begin
                dout_o = din_i;
                cout_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bsu_bitop.sv
module bsu_bitop #(
    parameter int W = 8,
    parameter int SEL_W = 3
) (
    input  logic [SEL_W-1:0] bit_i,
    input  logic             set_i,
    input  logic [W-1:0]     din_i,
    output logic [W-1:0]     dout_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        assign dout_o[g] = (bit_i == SEL_W'(g)) ? set_i : din_i[g];
    end

endmodule

// File: rtl/bsu_dest.sv
module bsu_dest
    import bsu_pkg::*;
(
    input  logic       indexed_i,
    input  grp_e       grp_i,
    input  logic [2:0] low_i,
    output logic       mem_we_o,
    output logic       reg_we_o,
    output logic [2:0] reg_idx_o
);
    logic writes;
    logic is_mem;

    assign writes    = (grp_i != GRP_TEST);
    assign is_mem    = (low_i == MEM_SEL);
    assign reg_idx_o = low_i;

    always_comb begin
        if (!writes) begin
            mem_we_o = 1'b0;
            reg_we_o = 1'b0;
        end else if (indexed_i) begin
            mem_we_o = 1'b1;
            reg_we_o = !is_mem;
        end else begin
            mem_we_o = is_mem;
            reg_we_o = !is_mem;
        end
    end

endmodule

// File: rtl/idx_bitshift_unit.sv
module idx_bitshift_unit
    import bsu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         indexed_i,
    input  logic [7:0]   op_i,
    input  logic [W-1:0] opnd_i,
    input  logic [7:0]   flags_i,
    output logic         valid_o,
    output logic [W-1:0] result_o,
    output logic [7:0]   flags_o,
    output logic         mem_we_o,
    output logic         reg_we_o,
    output logic [2:0]   reg_idx_o
);
    localparam int MSB = W - 1;

    typedef struct packed {
        logic         valid;
        logic         mem_we;
        logic         reg_we;
        logic [2:0]   reg_idx;
        logic [W-1:0] result;
        logic [7:0]   flags;
    } st_t;

    st_t st_d, st_q;

    grp_e         grp;
    shop_e        shsel;
    logic [W-1:0] sh_res;
    logic         sh_cout;
    logic [W-1:0] bit_res;
    logic         dst_mem, dst_reg;
    logic [2:0]   dst_idx;

    assign grp   = grp_e'(op_i[7:6]);
    assign shsel = shop_e'(op_i[5:3]);

    bsu_shifter #(.W(W)) u_shift (
        .sel_i  (shsel),
        .din_i  (opnd_i),
        .cin_i  (flags_i[FL_C]),
        .dout_o (sh_res),
        .cout_o (sh_cout)
    );

    bsu_bitop #(.W(W), .SEL_W(3)) u_bitop (
        .bit_i  (op_i[5:3]),
        .set_i  (op_i[6]),
        .din_i  (opnd_i),
        .dout_o (bit_res)
    );

    bsu_dest u_dest (
        .indexed_i (indexed_i),
        .grp_i     (grp),
        .low_i     (op_i[2:0]),
        .mem_we_o  (dst_mem),
        .reg_we_o  (dst_reg),
        .reg_idx_o (dst_idx)
    );

    always_comb begin
        st_d        = st_q;
        st_d.valid  = 1'b0;
        st_d.mem_we = 1'b0;
        st_d.reg_we = 1'b0;
        if (start_i) begin
            st_d.valid   = 1'b1;
            st_d.mem_we  = dst_mem;
            st_d.reg_we  = dst_reg;
            st_d.reg_idx = dst_idx;
            st_d.flags   = flags_i;
            unique case (grp)
                GRP_SHIFT: begin
                    st_d.result      = sh_res;
                    st_d.flags[FL_S] = sh_res[MSB];
                    st_d.flags[FL_Z] = (sh_res == '0);
                    st_d.flags[FL_H] = 1'b0;
                    st_d.flags[FL_P] = ~^sh_res;
                    st_d.flags[FL_N] = 1'b0;
                    st_d.flags[FL_C] = sh_cout;
                end
                GRP_CLR, GRP_SETB: st_d.result = bit_res;
                default:           st_d.result = opnd_i;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o   = st_q.valid;
    assign result_o  = st_q.result;
    assign flags_o   = st_q.flags;
    assign mem_we_o  = st_q.mem_we;
    assign reg_we_o  = st_q.reg_we;
    assign reg_idx_o = st_q.reg_idx;

endmodule

// File: rtl/bsu_chk.sv
module bsu_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         indexed_i,
    input logic [7:0]   op_i,
    input logic [7:0]   flags_i,
    input logic         valid_o,
    input logic [W-1:0] result_o,
    input logic [7:0]   flags_o,
    input logic         mem_we_o,
    input logic         reg_we_o,
    input logic [2:0]   reg_idx_o
);
    // R2
    start_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> valid_o);

    // R2
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !valid_o);

    // R12
    strobe_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o || reg_we_o) |-> valid_o);

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(result_o) && $stable(flags_o)));

    // R7
    bitop_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i[7]) |=> (flags_o == $past(flags_i)));

    // R8
    idx_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && indexed_i && op_i[7:6] != 2'b01 && op_i[2:0] != 3'd6)
        |=> (mem_we_o && reg_we_o && reg_idx_o == $past(op_i[2:0])));

    // R9
    idx_mem_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && indexed_i && op_i[7:6] != 2'b01 && op_i[2:0] == 3'd6)
        |=> (mem_we_o && !reg_we_o));

    // R10
    plain_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !indexed_i && op_i[7:6] != 2'b01)
        |=> ($countones({mem_we_o, reg_we_o}) == 1));

    // R11
    test_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i[7:6] == 2'b01) |=> (!mem_we_o && !reg_we_o));

endmodule

bind idx_bitshift_unit bsu_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .indexed_i (indexed_i),
    .op_i      (op_i),
    .flags_i   (flags_i),
    .valid_o   (valid_o),
    .result_o  (result_o),
    .flags_o   (flags_o),
    .mem_we_o  (mem_we_o),
    .reg_we_o  (reg_we_o),
    .reg_idx_o (reg_idx_o)
);

// File: tb/sim_idx_bitshift_unit.sv
`timescale 1ns/1ps
module sim_idx_bitshift_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       indexed_i = 1'b0;
    logic [7:0] op_i = '0;
    logic [7:0] opnd_i = '0;
    logic [7:0] flags_i = '0;
    logic       valid_o;
    logic [7:0] result_o;
    logic [7:0] flags_o;
    logic       mem_we_o;
    logic       reg_we_o;
    logic [2:0] reg_idx_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    idx_bitshift_unit #(.W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .indexed_i(indexed_i),
        .op_i(op_i), .opnd_i(opnd_i), .flags_i(flags_i), .valid_o(valid_o),
        .result_o(result_o), .flags_o(flags_o), .mem_we_o(mem_we_o),
        .reg_we_o(reg_we_o), .reg_idx_o(reg_idx_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] ref_shift(logic [2:0] s, logic [7:0] x, logic c);
        // returns {carry_out, result}
        case (s)
            3'd0: return {x[7], x[6:0], x[7]};
            3'd1: return {x[0], x[0], x[7:1]};
            3'd2: return {x[7], x[6:0], c};
            3'd3: return {x[0], c, x[7:1]};
            3'd4, 3'd6: return {x[7], x << 1};
            3'd5: return {x[0], x[7], x[7:1]};
            default: return {x[0], x >> 1};
        endcase
    endfunction

    function automatic logic [7:0] ref_res(logic [7:0] op, logic [7:0] x, logic [7:0] f);
        logic [8:0] r;
        if (op[7:6] == 2'b00) begin
            r = ref_shift(op[5:3], x, f[0]);
            return r[7:0];
        end
        if (op[7:6] == 2'b10) return x & ~(8'd1 << op[5:3]);
        if (op[7:6] == 2'b11) return x | (8'd1 << op[5:3]);
        return x;
    endfunction

    function automatic logic [7:0] ref_flags(logic [7:0] op, logic [7:0] x, logic [7:0] f);
        logic [8:0] r;
        if (op[7:6] != 2'b00) return f;
        r = ref_shift(op[5:3], x, f[0]);
        return {r[7], r[7:0] == 8'd0, f[5], 1'b0, f[3], ~^r[7:0], 1'b0, r[8]};
    endfunction

    // Runs one operation and checks it in the cycle valid_o is high
    task automatic run_op(bit idx, logic [7:0] op, logic [7:0] x, logic [7:0] f);
        bit wr, em, er;
        @(negedge clk);
        start_i = 1'b1; indexed_i = idx; op_i = op; opnd_i = x; flags_i = f;
        @(negedge clk);
        start_i = 1'b0;
        wr = (op[7:6] != 2'b01);
        em = wr && (idx || op[2:0] == 3'd6);
        er = wr && (op[2:0] != 3'd6);
        chk("R2 valid pulse", valid_o, 1);
        chk(op[7] ? "R7 result" : (op[6] ? "R11 result" : "R3/R4/R5 result"),
            result_o, ref_res(op, x, f));
        chk(op[7:6] == 2'b00 ? "R6 flags" : "R7/R11 flags", flags_o, ref_flags(op, x, f));
        chk(idx ? "R8/R9 mem_we" : "R10 mem_we", mem_we_o, em);
        chk(idx ? "R8/R9 reg_we" : "R10 reg_we", reg_we_o, er);
        if (er) chk("R8 reg_idx", reg_idx_o, op[2:0]);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] hr, hf;
        void'($urandom(32'd1234));
        #1;
        chk("R1 valid in reset", valid_o, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid", valid_o, 0);
        chk("R1 mem_we", mem_we_o, 0);
        chk("R1 reg_we", reg_we_o, 0);
        chk("R1 result", result_o, 0);
        chk("R1 flags", flags_o, 0);
        // R3 directed: RLC 0x80 -> 0x01, C=1
        run_op(1, 8'h00, 8'h80, 8'h00);
        chk("R3 rlc", result_o, 8'h01);
        run_op(0, 8'h09, 8'h01, 8'h00);
        chk("R3 rrc", result_o, 8'h80);
        run_op(1, 8'h12, 8'h00, 8'h01);
        chk("R3 rl carry in", result_o, 8'h01);
        run_op(0, 8'h1F, 8'h00, 8'h01);
        chk("R3 rr carry in", result_o, 8'h80);
        // R4: SLA and 0x30 slot equal
        run_op(1, 8'h20, 8'hC3, 8'h00);
        chk("R4 sla", result_o, 8'h86);
        run_op(1, 8'h30, 8'hC3, 8'h00);
        chk("R4 slx", result_o, 8'h86);
        chk("R4 slx carry", flags_o[0], 1);
        // R5
        run_op(0, 8'h2F, 8'h81, 8'h00);
        chk("R5 sra", result_o, 8'hC0);
        run_op(0, 8'h3F, 8'h81, 8'h00);
        chk("R5 srl", result_o, 8'h40);
        // R6: zero result sets Z and P
        run_op(0, 8'h38, 8'h01, 8'hFF);
        chk("R6 flags zero", flags_o, 8'h6D);
        // R7
        run_op(1, 8'h88, 8'hFF, 8'h5A);
        chk("R7 res1", result_o, 8'hFD);
        run_op(1, 8'hF8, 8'h00, 8'hA5);
        chk("R7 set7", result_o, 8'h80);
        // R9 / R10 memory-only field
        run_op(1, 8'hC6, 8'h00, 8'h00);
        run_op(0, 8'h36, 8'h11, 8'h00);
        // R11 test group
        run_op(1, 8'h47, 8'h3C, 8'h99);
        // R12 idle hold
        hr = result_o; hf = flags_o;
        repeat (4) begin
            @(negedge clk);
            chk("R12 hold result", result_o, hr);
            chk("R12 hold flags", flags_o, hf);
            chk("R12 no mem_we", mem_we_o, 0);
            chk("R12 no reg_we", reg_we_o, 0);
            chk("R2 single pulse", valid_o, 0);
        end
        // random mix
        for (int i = 0; i < 400; i++) begin
            run_op(1'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule